// File: doc/BRIEF.md
# FEC Channel Output Formatter

This block sits between a forward-error-correction decoder and a transport demultiplexer. The decoder hands over one byte at a time through a valid/ready handshake. Each byte carries three tags: whether it is corrected payload or a check/gap byte, whether it opens a frame, and whether its frame is uncorrectable. The formatter registers the byte and drives it onto an 8-bit channel bus. It also drives a data-valid flag, a byte strobe, a frame-start pulse and an active-low error flag, all timed to the data they describe.

A mode input picks the bus format. With the mode at 1 the whole byte appears on the bus in one clock. With the mode at 0 the byte leaves on bus bit 0, one bit per clock, most significant bit first. In that mode the decoder is held off until the last bit has gone. The mode is only looked at between bytes. An active-low enable floats every channel output without stopping the pipeline. A synchronous soft reset clears the output state and aborts a byte that is being shifted.

Top module: `fec_out_fmt`

## Requirements
- R1: In parallel mode (par_mode_i=1) a byte accepted at a clock edge (in_valid_i and in_ready_o both high) appears on co_o[7:0] right after that edge. in_ready_o is high whenever no serial byte is pending and fec_rst_i is low.
- R2: In parallel mode bstrb_o is high for exactly the one clock that follows the acceptance of each payload byte, and low otherwise. In serial mode bstrb_o stays low.
- R3: In serial mode (par_mode_i=0) an accepted byte leaves on co_o[0] over 8 consecutive clocks, bit 7 first and bit 0 last, starting right after the accepting edge. co_o[7:1] read 0.
- R4: In serial mode in_ready_o is low for the 7 clocks after an accepting edge and high in the 8th, so back-to-back bytes shift with no idle bit. dvalid_o holds one value for all 8 bit periods.
- R5: dvalid_o is high only for bytes tagged payload (in_payload_i=1). For check/gap bytes and idle clocks it is low, while the bus still carries the byte.
- R6: fstart_o is high for one byte period (parallel) or for the first bit period (serial) of a payload byte tagged in_sof_i=1. It is low at all other times.
- R7: The in_bad_i tag is sampled only on a byte that has in_sof_i=1. err_no goes low together with the first byte of a flagged frame and stays low through every byte up to the next start-of-frame byte. It returns high only when that next frame is clean. in_bad_i on other bytes has no effect.
- R8: With oe_ni=1, co_o, dvalid_o, bstrb_o, fstart_o and err_no float (high impedance). Bytes accepted meanwhile still update the state, which shows once oe_ni returns to 0.
- R9: With fec_rst_i=1, in_ready_o is low. After the next edge, dvalid_o, bstrb_o and fstart_o are 0, co_o is 0 and err_no is 1. A byte being shifted out is dropped.
- R10: A change of par_mode_i while a serial byte is still shifting does not alter that byte. The new mode applies from the next accepted byte.
- R11: After rst_ni is released, co_o=0, dvalid_o=0, bstrb_o=0, fstart_o=0, err_no=1 and in_ready_o=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, also the serial bit clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| fec_rst_i | input | 1 | Synchronous soft reset of the output state |
| par_mode_i | input | 1 | 1 = parallel byte output, 0 = serial on co_o[0] |
| oe_ni | input | 1 | Active-low output enable |
| in_valid_i | input | 1 | Decoder byte valid |
| in_ready_o | output | 1 | Formatter can take a byte |
| in_data_i | input | 8 | Decoded byte |
| in_payload_i | input | 1 | 1 = corrected payload, 0 = check/gap byte |
| in_sof_i | input | 1 | Byte is the first payload byte of a frame |
| in_bad_i | input | 1 | Frame is uncorrectable (sampled with in_sof_i) |
| co_o | output | 8 | Channel data bus |
| dvalid_o | output | 1 | Bus carries payload data |
| bstrb_o | output | 1 | Byte strobe, parallel mode |
| fstart_o | output | 1 | Frame start pulse |
| err_no | output | 1 | Active-low uncorrectable-frame flag |

## Verification
Two events can land on the same edge: the frame-start byte that moves the error flag, and the first bit of a new serial byte that has to follow the previous byte's last bit with no gap. The sweeps feed frames in both modes, with clean, bad and back-to-back bad frames. Start-of-frame bytes fall right after gap bytes, and the next byte is always queued while the last bit is still shifting. Each clock is judged against an arithmetic model of bit order, valid, strobe, frame start and frame error. A serial byte that is cut short by a soft reset, or by a mode change made mid-byte, is checked bit by bit against the same model.

// File: rtl/fec_out_pkg.sv
package fec_out_pkg;
  typedef enum logic {
    MODE_SER = 1'b0,
    MODE_PAR = 1'b1
  } out_mode_e;
endpackage

// File: rtl/fec_out_path.sv
module fec_out_path
  import fec_out_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  out_mode_e         mode_i,
  input  logic              valid_i,
  output logic              ready_o,
  output logic              accept_o,
  input  logic [DATA_W-1:0] data_i,
  input  logic              payload_i,
  input  logic              sof_i,
  output logic [DATA_W-1:0] co_o,
  output logic              dv_o,
  output logic              strb_o,
  output logic              fs_o
);
  localparam int unsigned CNT_W = (DATA_W > 2) ? $clog2(DATA_W) : 1;
  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(DATA_W - 1);

  logic [CNT_W-1:0]  left_q;
  logic [DATA_W-1:0] sh_q, co_q;
  logic              dv_q, strb_q, fs_q;
  logic              idle;

  assign idle     = (left_q == '0);
  assign ready_o  = idle & ~clr_i;
  assign accept_o = valid_i & ready_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      left_q <= '0;
      sh_q   <= '0;
      co_q   <= '0;
      dv_q   <= 1'b0;
      strb_q <= 1'b0;
      fs_q   <= 1'b0;
    end else if (clr_i) begin
      left_q <= '0;
      sh_q   <= '0;
      co_q   <= '0;
      dv_q   <= 1'b0;
      strb_q <= 1'b0;
      fs_q   <= 1'b0;
    end else if (accept_o) begin
      dv_q <= payload_i;
      fs_q <= payload_i & sof_i;
      if (mode_i == MODE_PAR) begin
        co_q   <= data_i;
        strb_q <= payload_i;
        left_q <= '0;
      end else begin
        // mode sampled only here: byte boundary
        co_q   <= {{(DATA_W-1){1'b0}}, data_i[DATA_W-1]};
        sh_q   <= data_i << 1;
        left_q <= LAST_CNT;
        strb_q <= 1'b0;
      end
    end else if (!idle) begin
      co_q   <= {{(DATA_W-1){1'b0}}, sh_q[DATA_W-1]};
      sh_q   <= sh_q << 1;
      left_q <= left_q - 1'b1;
      fs_q   <= 1'b0;
      strb_q <= 1'b0;
    end else begin
      dv_q   <= 1'b0;
      strb_q <= 1'b0;
      fs_q   <= 1'b0;
    end
  end

  assign co_o   = co_q;
  assign dv_o   = dv_q;
  assign strb_o = strb_q;
  assign fs_o   = fs_q;

  assert_serial_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!idle && !clr_i) |=> (dv_q == $past(dv_q)));
  assert_backpressure_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept_o && mode_i == MODE_SER) |=> !ready_o);
  assert_strobe_payload_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    strb_q |-> (dv_q && idle));
  assert_fstart_payload_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fs_q |-> dv_q);
  assert_soft_reset_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (!dv_q && !strb_q && !fs_q && idle));
endmodule

// File: rtl/fec_out_errtrk.sv
module fec_out_errtrk (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic accept_i,
  input  logic sof_i,
  input  logic bad_i,
  output logic bad_o
);
  logic bad_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                bad_q <= 1'b0;
    else if (clr_i)             bad_q <= 1'b0;
    else if (accept_i && sof_i) bad_q <= bad_i;
  end

  assign bad_o = bad_q;

  assert_err_frame_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && !(accept_i && sof_i)) |=> $stable(bad_q));
endmodule

// File: rtl/fec_out_tsdrv.sv
module fec_out_tsdrv #(
  parameter int unsigned W = 12
) (
  input  logic         oe_ni,
  input  logic [W-1:0] d_i,
  output wire  [W-1:0] q_o
);
  assign q_o = oe_ni ? {W{1'bz}} : d_i;
endmodule

// File: rtl/fec_out_fmt.sv
module fec_out_fmt
  import fec_out_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              fec_rst_i,
  input  logic              par_mode_i,
  input  logic              oe_ni,
  input  logic              in_valid_i,
  output logic              in_ready_o,
  input  logic [DATA_W-1:0] in_data_i,
  input  logic              in_payload_i,
  input  logic              in_sof_i,
  input  logic              in_bad_i,
  output wire  [DATA_W-1:0] co_o,
  output wire               dvalid_o,
  output wire               bstrb_o,
  output wire               fstart_o,
  output wire               err_no
);
  localparam int unsigned OUT_W = DATA_W + 4;

  logic [DATA_W-1:0] co_int;
  logic              dv_int, strb_int, fs_int, bad_int, accept;
  out_mode_e         mode;

  assign mode = par_mode_i ? MODE_PAR : MODE_SER;

  fec_out_path #(.DATA_W(DATA_W)) u_path (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clr_i    (fec_rst_i),
    .mode_i   (mode),
    .valid_i  (in_valid_i),
    .ready_o  (in_ready_o),
    .accept_o (accept),
    .data_i   (in_data_i),
    .payload_i(in_payload_i),
    .sof_i    (in_sof_i),
    .co_o     (co_int),
    .dv_o     (dv_int),
    .strb_o   (strb_int),
    .fs_o     (fs_int)
  );

  fec_out_errtrk u_err (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (fec_rst_i),
    .accept_i(accept),
    .sof_i   (in_sof_i & in_payload_i),
    .bad_i   (in_bad_i),
    .bad_o   (bad_int)
  );

  fec_out_tsdrv #(.W(OUT_W)) u_drv (
    .oe_ni(oe_ni),
    .d_i  ({~bad_int, fs_int, strb_int, dv_int, co_int}),
    .q_o  ({err_no, fstart_o, bstrb_o, dvalid_o, co_o})
  );

  assert_err_with_frame_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fs_int && !$past(fec_rst_i)) |-> (bad_int == $past(in_bad_i)));
endmodule

// File: tb/tb_fec_out_fmt.sv
`timescale 1ns/1ps
module tb_fec_out_fmt;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic fec_rst = 1'b0, par_mode = 1'b1, oe_n = 1'b0;
  logic in_valid = 1'b0, in_payload = 1'b0, in_sof = 1'b0, in_bad = 1'b0;
  logic [7:0] in_data = '0;
  logic in_ready;
  wire [7:0] co_w;
  wire dv_w, bs_w, fs_w, er_w;

  for (genvar g = 0; g < 8; g++) begin : g_pu
    pullup (co_w[g]);
  end
  pullup (dv_w);
  pullup (bs_w);
  pullup (fs_w);
  pullup (er_w);

  always #2.5 clk = ~clk;

  fec_out_fmt dut (
    .clk_i(clk), .rst_ni(rst_n), .fec_rst_i(fec_rst), .par_mode_i(par_mode),
    .oe_ni(oe_n), .in_valid_i(in_valid), .in_ready_o(in_ready),
    .in_data_i(in_data), .in_payload_i(in_payload), .in_sof_i(in_sof),
    .in_bad_i(in_bad), .co_o(co_w), .dvalid_o(dv_w), .bstrb_o(bs_w),
    .fstart_o(fs_w), .err_no(er_w)
  );

  int n_vec = 0, n_err = 0;
  logic bad_m = 1'b0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s act=%h exp=%h t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic drive(input logic [7:0] d, input logic pl, input logic sof, input logic bad);
    in_valid = 1'b1; in_data = d; in_payload = pl; in_sof = sof; in_bad = bad;
  endtask

  // called at a negedge; returns at the negedge after the accepting edge
  task automatic send_par(input logic [7:0] d, input logic pl, input logic sof, input logic bad);
    drive(d, pl, sof, bad);
    chk("R1 ready", 32'(in_ready), 32'd1);
    @(posedge clk); @(negedge clk);
    in_valid = 1'b0;
    if (sof && pl) bad_m = bad;
    chk("R1 data", 32'(co_w), 32'(d));
    chk("R5 valid", 32'(dv_w), 32'(pl));
    chk("R2 strobe", 32'(bs_w), 32'(pl));
    chk("R6 fstart", 32'(fs_w), 32'(sof & pl));
    chk("R7 err", 32'(er_w), 32'(!bad_m));
  endtask

  task automatic send_ser(input logic [7:0] d, input logic pl, input logic sof,
                          input logic bad, input int flip_at);
    drive(d, pl, sof, bad);
    chk("R4 ready idle", 32'(in_ready), 32'd1);
    @(posedge clk); @(negedge clk);
    in_valid = 1'b0;
    if (sof && pl) bad_m = bad;
    for (int i = 7; i >= 0; i--) begin
      if (i != 7) begin @(posedge clk); @(negedge clk); end
      chk("R3 bit", 32'(co_w[0]), 32'(d[i]));
      chk("R3 upper", 32'(co_w[7:1]), 32'd0);
      chk("R4 valid hold", 32'(dv_w), 32'(pl));
      chk("R4 ready", 32'(in_ready), 32'(i == 0));
      chk("R6 fstart", 32'(fs_w), 32'((i == 7) && sof && pl));
      chk("R2 strobe ser", 32'(bs_w), 32'd0);
      chk("R7 err", 32'(er_w), 32'(!bad_m));
      if (i == flip_at) par_mode = 1'b1;
    end
  endtask

  task automatic gen(input int i, output logic [7:0] d, output logic pl,
                     output logic sof, output logic bad);
    int f;
    f   = i / 12;
    d   = 8'(i) ^ 8'h5A;
    pl  = (i % 6) != 5;
    sof = (i % 12) == 0;
    bad = sof ? ((f % 4 == 1) || (f % 4 == 2)) : ((i % 7) == 3);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog act=hung exp=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
    $finish;
  end

  initial begin
    logic [7:0] d;
    logic pl, sof, bad;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R11 co", 32'(co_w), 32'd0);
    chk("R11 dv", 32'(dv_w), 32'd0);
    chk("R11 bs", 32'(bs_w), 32'd0);
    chk("R11 fs", 32'(fs_w), 32'd0);
    chk("R11 err", 32'(er_w), 32'd1);
    chk("R11 ready", 32'(in_ready), 32'd1);

    // parallel sweep, back-to-back
    par_mode = 1'b1;
    for (int i = 0; i < 256; i++) begin
      gen(i, d, pl, sof, bad);
      send_par(d, pl, sof, bad);
    end
    @(posedge clk); @(negedge clk);
    chk("R5 idle valid", 32'(dv_w), 32'd0);
    chk("R2 idle strobe", 32'(bs_w), 32'd0);

    // serial sweep, back-to-back
    par_mode = 1'b0;
    for (int i = 0; i < 96; i++) begin
      gen(i + 7, d, pl, sof, bad);
      send_ser(d, pl, sof, bad, -1);
    end

    // mode change mid-byte (R10)
    send_ser(8'hC6, 1'b1, 1'b1, 1'b0, 5);
    chk("R10 mode applied", 32'(par_mode), 32'd1);
    send_par(8'h39, 1'b1, 1'b0, 1'b1);
    chk("R10 next byte parallel", 32'(co_w), 32'h39);

    // tri-state (R8)
    send_par(8'h11, 1'b1, 1'b1, 1'b0);
    send_par(8'h00, 1'b0, 1'b0, 1'b0);
    oe_n = 1'b1;
    #1;
    chk("R8 co z", 32'(co_w), 32'hFF);
    chk("R8 dv z", 32'(dv_w), 32'd1);
    chk("R8 bs z", 32'(bs_w), 32'd1);
    chk("R8 fs z", 32'(fs_w), 32'd1);
    chk("R8 err z", 32'(er_w), 32'd1);
    drive(8'h3C, 1'b1, 1'b1, 1'b1);
    @(posedge clk); @(negedge clk);
    in_valid = 1'b0;
    bad_m = 1'b1;
    chk("R8 co still z", 32'(co_w), 32'hFF);
    oe_n = 1'b0;
    #1;
    chk("R8 co after", 32'(co_w), 32'h3C);
    chk("R8 dv after", 32'(dv_w), 32'd1);
    chk("R8 fs after", 32'(fs_w), 32'd1);
    chk("R8 err after", 32'(er_w), 32'd0);

    // soft reset mid serial byte (R9)
    @(negedge clk);
    par_mode = 1'b0;
    drive(8'hA5, 1'b1, 1'b1, 1'b1);
    @(posedge clk); @(negedge clk);
    in_valid = 1'b0;
    chk("R3 bit7", 32'(co_w[0]), 32'd1);
    @(posedge clk); @(negedge clk);
    chk("R3 bit6", 32'(co_w[0]), 32'd0);
    fec_rst = 1'b1;
    #1;
    chk("R9 ready low", 32'(in_ready), 32'd0);
    @(posedge clk); @(negedge clk);
    chk("R9 dv", 32'(dv_w), 32'd0);
    chk("R9 co", 32'(co_w), 32'd0);
    chk("R9 fs", 32'(fs_w), 32'd0);
    chk("R9 bs", 32'(bs_w), 32'd0);
    chk("R9 err", 32'(er_w), 32'd1);
    chk("R9 ready held", 32'(in_ready), 32'd0);
    fec_rst = 1'b0;
    bad_m = 1'b0;
    #1;
    chk("R9 ready back", 32'(in_ready), 32'd1);
    @(posedge clk); @(negedge clk);
    chk("R9 shift dropped", 32'(co_w), 32'd0);
    chk("R9 dv idle", 32'(dv_w), 32'd0);
    send_ser(8'h81, 1'b1, 1'b1, 1'b0, -1);

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
    $finish;
  end
endmodule